// File: doc/BRIEF.md
# Endian-Selectable Byte-Lane Load/Store Unit

This block sits between a 32-bit processor datapath and a data memory organised as 32-bit words but addressed by byte. It forms the effective address from a base register value and a signed 16-bit displacement. It drives the word address of the access. For stores, it places the operand on the correct byte lanes and raises only the matching write enables. For loads, it takes the returned memory word and picks out the addressed byte, halfword or word. It right-justifies that item and extends it, then presents it one cycle later with a valid strobe.

Byte ordering is chosen by a static mode input. In big-endian mode the most significant byte of an item sits at its lowest byte address. In little-endian mode the least significant byte sits there. Byte lane k of the memory word is bits 8k+7..8k. Halfword accesses must be 2-byte aligned and word accesses 4-byte aligned. A violation raises a misalignment flag, and the access then writes nothing and returns no load.

Top module: `bytelane_lsu`

## Requirements
- R1: The effective address is base plus the 16-bit displacement sign-extended to 32 bits. mem_addr equals that address with its two low bits cleared.
- R2: Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. With req_valid high, misalign is 1 for a halfword whose address bit 0 is 1, or a word whose two low address bits are not both 0. When misalign is 1, mem_we is 0. Byte accesses never raise misalign.
- R3: An aligned byte store at offset a (the two low address bits) enables only lane 3-a in big-endian mode (big_endian=1), or lane a in little-endian mode. Write data is the low store byte copied to all four lanes.
- R4: A halfword store enables lanes 3 and 2 (mem_we=4'b1100) when big-endian with a=0, or little-endian with a=2. Otherwise it enables lanes 1 and 0 (4'b0011). Write data is the low store halfword copied to both halves.
- R5: An aligned word store sets mem_we to 4'b1111 and mem_wdata to the store data unchanged.
- R6: When no store is requested (req_valid low, or req_store low), mem_we is 0.
- R7: A byte load returns the byte from the lane chosen as in R3. It is sign-extended, or zero-extended when req_unsigned is 1.
- R8: A halfword load returns the half chosen as in R4, taken with lane order kept. It is sign-extended, or zero-extended when req_unsigned is 1.
- R9: A word load returns mem_rdata unchanged.
- R10: load_valid is high in the cycle after an aligned load request and low otherwise. load_data changes only on such a load.
- R11: After storing the word 0x87654321 at a word address, byte loads of offsets 0 to 3 return 0x87, 0x65, 0x43, 0x21 in big-endian mode. In little-endian mode they return 0x21, 0x43, 0x65, 0x87.
- R12: During reset, load_valid and load_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Byte order mode, 1 = big-endian |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| base_addr | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Store operand, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Word read from memory for this request |
| misalign | output | 1 | Misaligned access flag |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extracted, extended load result |

## Verification
Lane steering and misalignment decoding are combinational. A wrong lane index or a wrong half choice therefore shows at mem_we or mem_wdata in the same cycle as the request. A missed alignment check shows there too, as a stray write enable. The load register shows its errors one cycle later: a wrong extension, or a wrong lane picked, gives a bad load_data exactly when load_valid rises. A broken capture condition shows as load_data drifting while no load is pending, or as a strobe that is missing or extra. The bench sweeps every size, offset, byte order and extension choice, so each such fault is seen on its first matching request.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;
endpackage

// File: rtl/bytelane_agen.sv
module bytelane_agen
   import bytelane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int OFS_W  = 2
) (
   input  logic              req_valid,
   input  acc_size_e         size,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] word_addr,
   output logic [OFS_W-1:0]  ofs,
   output logic              misalign
);
   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] eff;
   logic              bad;

   assign eff       = base_addr + {{EXT_W{disp[DISP_W-1]}}, disp};
   assign ofs       = eff[OFS_W-1:0];
   assign word_addr = {eff[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

   always_comb begin
      unique case (size)
         SZ_BYTE: bad = 1'b0;
         SZ_HALF: bad = eff[0];
         default: bad = |eff[OFS_W-1:0];
      endcase
   end

   assign misalign = req_valid & bad;
endmodule

// File: rtl/bytelane_store.sv
module bytelane_store
   import bytelane_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = 4,
   parameter int LANE_W = 2
) (
   input  logic              en,
   input  acc_size_e         size,
   input  logic [LANE_W-1:0] lane,
   input  logic [DATA_W-1:0] sdata,
   output logic [LANES-1:0]  we,
   output logic [DATA_W-1:0] wdata
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [LANE_W-1:0] K_IDX = LANE_W'(k);
      logic hit;

      always_comb begin
         unique case (size)
            SZ_BYTE: hit = (lane == K_IDX);
            SZ_HALF: hit = (lane[LANE_W-1:1] == K_IDX[LANE_W-1:1]);
            default: hit = 1'b1;
         endcase
      end

      always_comb begin
         unique case (size)
            SZ_BYTE: wdata[8*k +: 8] = sdata[7:0];
            SZ_HALF: wdata[8*k +: 8] = sdata[8*(k%2) +: 8];
            default: wdata[8*k +: 8] = sdata[8*k +: 8];
         endcase
      end

      assign we[k] = en & hit;
   end
endmodule

// File: rtl/bytelane_load.sv
module bytelane_load
   import bytelane_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  acc_size_e         size,
   input  logic [LANE_W-1:0] lane,
   input  logic              uns,
   input  logic [DATA_W-1:0] rdata,
   output logic              load_valid,
   output logic [DATA_W-1:0] load_data
);
   localparam int HALF_IDX_W = LANE_W - 1;

   logic [7:0]        byte_v;
   logic [15:0]       half_v;
   logic [DATA_W-1:0] ext_v;
   logic [HALF_IDX_W-1:0] hsel;

   assign hsel   = lane[LANE_W-1:1];
   assign byte_v = rdata[{lane, 3'b000} +: 8];
   assign half_v = rdata[{hsel, 4'b0000} +: 16];

   always_comb begin
      unique case (size)
         SZ_BYTE: ext_v = {{(DATA_W-8){~uns & byte_v[7]}}, byte_v};
         SZ_HALF: ext_v = {{(DATA_W-16){~uns & half_v[15]}}, half_v};
         default: ext_v = rdata;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_valid <= 1'b0;
         load_data  <= '0;
      end else begin
         load_valid <= take;
         if (take) load_data <= ext_v;
      end
   end
endmodule

// File: rtl/bytelane_lsu.sv
module bytelane_lsu
   import bytelane_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DISP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic              req_unsigned,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [DISP_W-1:0] disp,
   input  logic [DATA_W-1:0] store_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0] mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              misalign,
   output logic              load_valid,
   output logic [DATA_W-1:0] load_data
);
   localparam int LANES  = DATA_W / 8;
   localparam int LANE_W = $clog2(LANES);

   if (DATA_W != 32) begin : g_bad_width
      $error("bytelane_lsu: DATA_W must be 32");
   end
   if (DISP_W >= ADDR_W) begin : g_bad_disp
      $error("bytelane_lsu: DISP_W must be below ADDR_W");
   end

   acc_size_e         size;
   logic [LANE_W-1:0] ofs;
   logic [LANE_W-1:0] lane;

   assign size = acc_size_e'(req_size);
   assign lane = big_endian ? ~ofs : ofs;

   bytelane_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .OFS_W(LANE_W)) u_agen (
      .req_valid (req_valid),
      .size      (size),
      .base_addr (base_addr),
      .disp      (disp),
      .word_addr (mem_addr),
      .ofs       (ofs),
      .misalign  (misalign)
   );

   bytelane_store #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .en    (req_valid & req_store & ~misalign),
      .size  (size),
      .lane  (lane),
      .sdata (store_data),
      .we    (mem_we),
      .wdata (mem_wdata)
   );

   bytelane_load #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_load (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (req_valid & ~req_store & ~misalign),
      .size       (size),
      .lane       (lane),
      .uns        (req_unsigned),
      .rdata      (mem_rdata),
      .load_valid (load_valid),
      .load_data  (load_data)
   );
endmodule

// File: rtl/bytelane_lsu_chk.sv
module bytelane_lsu_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_store,
   input logic [1:0]        req_size,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W/8-1:0] mem_we,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              misalign,
   input logic              load_valid,
   input logic [DATA_W-1:0] load_data
);
   logic good_load;
   assign good_load = req_valid & ~req_store & ~misalign;

   assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_addr[1:0] == 2'b00);

   assert_no_we_misalign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> mem_we == '0);

   assert_byte_never_misaligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd0) |-> !misalign);

   assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && req_size == 2'd0) |-> $countones(mem_we) == 1);

   assert_half_two_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store && req_size == 2'd1 && !misalign)
         |-> (mem_we == 4'b1100 || mem_we == 4'b0011));

   assert_no_we_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_store) |-> mem_we == '0);

   assert_word_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (good_load && req_size[1]) |=> load_data == $past(mem_rdata));

   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      good_load |=> load_valid);

   assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !good_load |=> !load_valid);

   assert_data_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !good_load |=> $stable(load_data));
endmodule

bind bytelane_lsu bytelane_lsu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_store  (req_store),
   .req_size   (req_size),
   .mem_addr   (mem_addr),
   .mem_we     (mem_we),
   .mem_rdata  (mem_rdata),
   .misalign   (misalign),
   .load_valid (load_valid),
   .load_data  (load_data)
);

// File: tb/bytelane_lsu_bench.sv
module bytelane_lsu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_endian = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic        req_unsigned = 1'b0;
   logic [31:0] base_addr = '0;
   logic [15:0] disp = '0;
   logic [31:0] store_data = '0;
   logic [31:0] mem_addr;
   logic [3:0]  mem_we;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        misalign;
   logic        load_valid;
   logic [31:0] load_data;

   int checks = 0;
   int fails  = 0;
   logic [31:0] memw = '0;

   always #10 clk = ~clk;

   bytelane_lsu u_bytelane_lsu (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
      .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
      .req_unsigned(req_unsigned), .base_addr(base_addr), .disp(disp),
      .store_data(store_data), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign(misalign),
      .load_valid(load_valid), .load_data(load_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] lane_of(input logic be, input logic [1:0] a);
      return be ? 2'd3 - a : a;
   endfunction

   function automatic logic is_mis(input logic [1:0] sz, input logic [31:0] ea);
      if (sz == 2'd0) return 1'b0;
      if (sz == 2'd1) return ea[0];
      return ea[1:0] != 2'b00;
   endfunction

   task automatic drive(input logic st, input logic be, input logic [1:0] sz,
                        input logic uns, input logic [31:0] ea, input logic [15:0] d);
      big_endian   = be;
      req_valid    = 1'b1;
      req_store    = st;
      req_size     = sz;
      req_unsigned = uns;
      disp         = d;
      base_addr    = ea - {{16{d[15]}}, d};
   endtask

   task automatic do_store(input logic be, input logic [1:0] sz, input logic [31:0] ea,
                           input logic [15:0] d, input logic [31:0] data);
      logic mis;
      logic hi;
      @(negedge clk);
      drive(1'b1, be, sz, 1'b0, ea, d);
      store_data = data;
      #1;
      mis = is_mis(sz, ea);
      check("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
      check("R2 misalign", {31'd0, misalign}, {31'd0, mis});
      if (mis) begin
         check("R2 write blocked", {28'd0, mem_we}, 32'd0);
      end else if (sz == 2'd0) begin
         check("R3 byte we", {28'd0, mem_we}, 32'd1 << lane_of(be, ea[1:0]));
         check("R3 byte data", mem_wdata, {4{data[7:0]}});
      end else if (sz == 2'd1) begin
         hi = be ? (ea[1] == 1'b0) : (ea[1] == 1'b1);
         check("R4 half we", {28'd0, mem_we}, hi ? 32'hC : 32'h3);
         check("R4 half data", mem_wdata, {2{data[15:0]}});
      end else begin
         check("R5 word we", {28'd0, mem_we}, 32'hF);
         check("R5 word data", mem_wdata, data);
      end
      for (int k = 0; k < 4; k++)
         if (mem_we[k]) memw[8*k +: 8] = mem_wdata[8*k +: 8];
      @(negedge clk);
      check("R10 no valid after store", {31'd0, load_valid}, 32'd0);
      req_valid = 1'b0;
      #1;
      check("R6 idle we", {28'd0, mem_we}, 32'd0);
   endtask

   task automatic do_load(input logic be, input logic [1:0] sz, input logic uns,
                          input logic [31:0] ea, input logic [15:0] d,
                          input logic [31:0] rd, input logic [31:0] exp_fixed,
                          input logic use_fixed, input string tag);
      logic mis;
      logic [31:0] exp;
      logic [7:0]  b;
      logic [15:0] h;
      logic [1:0]  ln;
      @(negedge clk);
      drive(1'b0, be, sz, uns, ea, d);
      mem_rdata = rd;
      #1;
      mis = is_mis(sz, ea);
      ln  = lane_of(be, ea[1:0]);
      check("R6 load no we", {28'd0, mem_we}, 32'd0);
      check("R2 load misalign", {31'd0, misalign}, {31'd0, mis});
      b = rd[8*ln +: 8];
      h = ln[1] ? rd[31:16] : rd[15:0];
      if (sz == 2'd0)      exp = uns ? {24'd0, b} : {{24{b[7]}}, b};
      else if (sz == 2'd1) exp = uns ? {16'd0, h} : {{16{h[15]}}, h};
      else                 exp = rd;
      if (use_fixed) exp = exp_fixed;
      @(negedge clk);
      req_valid = 1'b0;
      mem_rdata = ~rd;
      if (mis) begin
         check("R10 no valid misaligned", {31'd0, load_valid}, 32'd0);
      end else begin
         check("R10 valid strobe", {31'd0, load_valid}, 32'd1);
         check(tag, load_data, exp);
         @(negedge clk);
         check("R10 valid drops", {31'd0, load_valid}, 32'd0);
         check("R10 data holds", load_data, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R12 reset valid", {31'd0, load_valid}, 32'd0);
      check("R12 reset data", load_data, 32'd0);
      rst_n = 1'b1;

      for (int be = 0; be < 2; be++)
         for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 4; a++)
               for (int p = 0; p < 2; p++)
                  do_store(1'(be), 2'(sz), 32'h2000_0100 + 32'(a),
                           p ? 16'hFFF0 : 16'h0024,
                           p ? 32'hA5C3_96F1 : 32'h1B7E_2D48);

      for (int be = 0; be < 2; be++)
         for (int sz = 0; sz < 3; sz++)
            for (int a = 0; a < 4; a++)
               for (int u = 0; u < 2; u++)
                  for (int p = 0; p < 2; p++)
                     do_load(1'(be), 2'(sz), 1'(u), 32'h3000_0040 + 32'(a),
                             p ? 16'h8004 : 16'h0010,
                             p ? 32'h8F70_E1C2 : 32'h7E81_19A6, 32'd0, 1'b0,
                             sz == 0 ? "R7 byte load" : (sz == 1 ? "R8 half load" : "R9 word load"));

      for (int be = 0; be < 2; be++) begin
         memw = '0;
         do_store(1'(be), 2'd2, 32'h0000_0100, 16'h0100, 32'h8765_4321);
         for (int a = 0; a < 4; a++)
            do_load(1'(be), 2'd0, 1'b1, 32'h0000_0100 + 32'(a), 16'h0100, memw,
                    be ? (a == 0 ? 32'h87 : a == 1 ? 32'h65 : a == 2 ? 32'h43 : 32'h21)
                       : (a == 0 ? 32'h21 : a == 1 ? 32'h43 : a == 2 ? 32'h65 : 32'h87),
                    1'b1, "R11 byte order");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule